// File: doc/BRIEF.md
# Cache Flush Writeback Sequencer

This block walks a small data cache and empties it safely. It writes every dirty line back to memory, and only after that does it drop every line. A whole-cache operation can start in two ways. One is an asynchronous active-low flush pin. The other is a single-cycle software write-back-and-invalidate command. Both use the same scan engine. The pin-started path first runs a flush-acknowledge special cycle on the bus side and waits for it to finish. The command path goes straight to the scan.

During a scan the sequencer visits the line indices one by one and looks at the line-state vector. It raises a writeback request only for lines marked modified, and it holds that request until the bus side reports the writeback finished. After the last index, a single pulse invalidates the whole array. There is also a lighter path for an internal snoop hit on one line. If that line is modified, it is written back and then invalidated. If it is clean, it is invalidated at once. This path is only taken while no whole-cache operation is running.

Top module: `flush_wb_seq`

## Requirements
- R1: A falling edge on `flush_n_i`, once through the synchroniser, starts an operation. The first thing that operation does is raise `spc_req_o`, and it holds `spc_req_o` until `spc_done_i`. No writeback request appears before that.
- R2: Each line whose `line_mod_i` bit is 1 when its index is scanned gets exactly one writeback request. `wb_req_o` stays high with a stable `wb_idx_o` until `wb_done_i` is sampled high.
- R3: Lines are visited in ascending index order, from 0 to NUM_LINES-1. A line whose `line_mod_i` bit is 0 produces no request.
- R4: `inval_all_o` is a one-cycle pulse. It comes only after the last writeback of the scan has completed. At most one of `spc_req_o`, `wb_req_o`, `inval_all_o` and `inval_one_o` is high in any cycle.
- R5: A one-cycle `wbinv_cmd_i` pulse while idle runs the same scan and invalidate-all sequence, with no special cycle.
- R6: `snoop_hit_i` while idle with a modified line at `snoop_idx_i` writes back that index and then pulses `inval_one_o` with `inval_idx_o` equal to that index. For a clean line, `inval_one_o` is pulsed with no writeback.
- R7: `snoop_hit_i` is ignored while `busy_o` is high.
- R8: A flush falling edge that arrives while busy is dropped. A flush input held low after an operation ends does not start another one.
- R9: `busy_o` goes high in the cycle after a trigger is accepted. It stays high until the invalidate step, and `done_o` pulses for one cycle just after that step, with `busy_o` low.
- R10: When `wbinv_cmd_i` and `snoop_hit_i` arrive in the same idle cycle, the command wins and the snoop is dropped.
- R11: After reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush_n_i | input | 1 | Asynchronous active-low flush request |
| wbinv_cmd_i | input | 1 | Software write-back-and-invalidate pulse |
| snoop_hit_i | input | 1 | Internal snoop hit on one line |
| snoop_idx_i | input | IDX_W | Line index of the snoop hit |
| line_mod_i | input | NUM_LINES | Modified flag per line |
| spc_req_o | output | 1 | Flush-acknowledge special-cycle request |
| spc_done_i | input | 1 | Special cycle finished |
| wb_req_o | output | 1 | Line writeback request |
| wb_idx_o | output | IDX_W | Index of the line being written back |
| wb_done_i | input | 1 | Writeback finished |
| inval_all_o | output | 1 | Invalidate every line (one cycle) |
| inval_one_o | output | 1 | Invalidate one line (one cycle) |
| inval_idx_o | output | IDX_W | Index for `inval_one_o` |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Operation finished (one cycle) |

## Verification
Several properties are checked on every cycle. Requests are held until their handshakes complete, and the writeback index stays stable while a request is pending. The four bus-side outputs are never high together. Each new writeback targets a modified line at a higher index than the previous one. Every invalidate is followed by `done_o` with `busy_o` low. Some behaviours can only be shown by the bench's scoreboard scenarios: that the special cycle appears only for the pin trigger, the exact set of lines written back, and that flush edges and snoops arriving mid-scan or a flush held low add no events.

// File: rtl/flush_wb_pkg.sv
package flush_wb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ACK,
      ST_SCAN,
      ST_WB,
      ST_INV_ALL,
      ST_SNP_WB,
      ST_SNP_INV
   } seq_state_e;

endpackage

// File: rtl/flush_sync.sv
module flush_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_n_i,
   output logic fall_o
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("flush_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b1;
               else        chain_q[0] <= async_n_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= 1'b1;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign fall_o = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/scan_ptr.sv
module scan_ptr #(
   parameter int NUM_LINES = 16,
   parameter int IDX_W     = $clog2(NUM_LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             step_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             last_o
);
   localparam bit                PWR2     = (NUM_LINES & (NUM_LINES - 1)) == 0;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       idx_q <= '0;
      else if (clear_i) idx_q <= '0;
      else if (step_i)  idx_q <= idx_q + 1'b1;
   end

   generate
      if (PWR2) begin : g_pwr2
         assign last_o = &idx_q;
      end else begin : g_cmp
         assign last_o = (idx_q == LAST_IDX);
      end
   endgenerate

   assign idx_o = idx_q;
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
   import flush_wb_pkg::*;
#(
   parameter int NUM_LINES = 16,
   parameter int IDX_W     = $clog2(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 flush_fall_i,
   input  logic                 cmd_i,
   input  logic                 snoop_hit_i,
   input  logic [IDX_W-1:0]     snoop_idx_i,
   input  logic [NUM_LINES-1:0] line_mod_i,
   input  logic [IDX_W-1:0]     ptr_idx_i,
   input  logic                 ptr_last_i,
   input  logic                 spc_done_i,
   input  logic                 wb_done_i,
   output logic                 ptr_clear_o,
   output logic                 ptr_step_o,
   output logic                 spc_req_o,
   output logic                 wb_req_o,
   output logic [IDX_W-1:0]     wb_idx_o,
   output logic                 inval_all_o,
   output logic                 inval_one_o,
   output logic [IDX_W-1:0]     inval_idx_o,
   output logic                 busy_o,
   output logic                 done_o
);
   seq_state_e       st_q, st_d;
   logic [IDX_W-1:0] snp_q;
   logic             snp_take;
   logic             done_q;

   always_comb begin
      st_d        = st_q;
      ptr_clear_o = 1'b0;
      ptr_step_o  = 1'b0;
      snp_take    = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (flush_fall_i) begin
               st_d        = ST_ACK;
               ptr_clear_o = 1'b1;
            end else if (cmd_i) begin
               st_d        = ST_SCAN;
               ptr_clear_o = 1'b1;
            end else if (snoop_hit_i) begin
               snp_take = 1'b1;
               st_d     = line_mod_i[snoop_idx_i] ? ST_SNP_WB : ST_SNP_INV;
            end
         end
         ST_ACK: if (spc_done_i) st_d = ST_SCAN;
         ST_SCAN: begin
            if (line_mod_i[ptr_idx_i]) begin
               st_d = ST_WB;
            end else if (ptr_last_i) begin
               st_d = ST_INV_ALL;
            end else begin
               ptr_step_o = 1'b1;
            end
         end
         ST_WB: begin
            if (wb_done_i) begin
               if (ptr_last_i) begin
                  st_d = ST_INV_ALL;
               end else begin
                  st_d       = ST_SCAN;
                  ptr_step_o = 1'b1;
               end
            end
         end
         ST_INV_ALL: st_d = ST_IDLE;
         ST_SNP_WB:  if (wb_done_i) st_d = ST_SNP_INV;
         ST_SNP_INV: st_d = ST_IDLE;
         default:    st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         snp_q  <= '0;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= (st_q == ST_INV_ALL) || (st_q == ST_SNP_INV);
         if (snp_take) snp_q <= snoop_idx_i;
      end
   end

   assign spc_req_o   = (st_q == ST_ACK);
   assign wb_req_o    = (st_q == ST_WB) || (st_q == ST_SNP_WB);
   assign wb_idx_o    = (st_q == ST_SNP_WB) ? snp_q : ptr_idx_i;
   assign inval_all_o = (st_q == ST_INV_ALL);
   assign inval_one_o = (st_q == ST_SNP_INV);
   assign inval_idx_o = snp_q;
   assign busy_o      = (st_q != ST_IDLE);
   assign done_o      = done_q;
endmodule

// File: rtl/flush_wb_seq.sv
module flush_wb_seq #(
   parameter int NUM_LINES   = 16,
   parameter int SYNC_STAGES = 2,
   parameter int IDX_W       = $clog2(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 flush_n_i,
   input  logic                 wbinv_cmd_i,
   input  logic                 snoop_hit_i,
   input  logic [IDX_W-1:0]     snoop_idx_i,
   input  logic [NUM_LINES-1:0] line_mod_i,
   output logic                 spc_req_o,
   input  logic                 spc_done_i,
   output logic                 wb_req_o,
   output logic [IDX_W-1:0]     wb_idx_o,
   input  logic                 wb_done_i,
   output logic                 inval_all_o,
   output logic                 inval_one_o,
   output logic [IDX_W-1:0]     inval_idx_o,
   output logic                 busy_o,
   output logic                 done_o
);
   generate
      if (NUM_LINES < 2) begin : g_bad_lines
         $error("flush_wb_seq: NUM_LINES must be at least 2");
      end
      if (IDX_W < $clog2(NUM_LINES)) begin : g_bad_idx
         $error("flush_wb_seq: IDX_W too narrow for NUM_LINES");
      end
   endgenerate

   logic             fall;
   logic             ptr_clear, ptr_step, ptr_last;
   logic [IDX_W-1:0] ptr_idx;

   flush_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_n_i(flush_n_i),
      .fall_o   (fall)
   );

   scan_ptr #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear_i(ptr_clear),
      .step_i (ptr_step),
      .idx_o  (ptr_idx),
      .last_o (ptr_last)
   );

   seq_ctrl #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush_fall_i(fall),
      .cmd_i       (wbinv_cmd_i),
      .snoop_hit_i (snoop_hit_i),
      .snoop_idx_i (snoop_idx_i),
      .line_mod_i  (line_mod_i),
      .ptr_idx_i   (ptr_idx),
      .ptr_last_i  (ptr_last),
      .spc_done_i  (spc_done_i),
      .wb_done_i   (wb_done_i),
      .ptr_clear_o (ptr_clear),
      .ptr_step_o  (ptr_step),
      .spc_req_o   (spc_req_o),
      .wb_req_o    (wb_req_o),
      .wb_idx_o    (wb_idx_o),
      .inval_all_o (inval_all_o),
      .inval_one_o (inval_one_o),
      .inval_idx_o (inval_idx_o),
      .busy_o      (busy_o),
      .done_o      (done_o)
   );
endmodule

// File: rtl/flush_wb_seq_chk.sv
module flush_wb_seq_chk #(
   parameter int NUM_LINES = 16,
   parameter int IDX_W     = $clog2(NUM_LINES)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] line_mod_i,
   input logic                 spc_req_o,
   input logic                 spc_done_i,
   input logic                 wb_req_o,
   input logic [IDX_W-1:0]     wb_idx_o,
   input logic                 wb_done_i,
   input logic                 inval_all_o,
   input logic                 inval_one_o,
   input logic                 busy_o,
   input logic                 done_o
);
   logic [IDX_W-1:0] last_q;
   logic             have_q;
   logic             wb_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q    <= '0;
         have_q    <= 1'b0;
         wb_prev_q <= 1'b0;
      end else begin
         wb_prev_q <= wb_req_o;
         if (done_o) begin
            have_q <= 1'b0;
         end else if (wb_req_o && !wb_prev_q) begin
            have_q <= 1'b1;
            last_q <= wb_idx_o;
         end
      end
   end

   // R1
   spc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spc_req_o && !spc_done_i |=> spc_req_o);

   // R2
   wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req_o && !wb_done_i |=> wb_req_o && $stable(wb_idx_o));

   // R2
   wb_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req_o && !wb_prev_q |-> line_mod_i[wb_idx_o]);

   // R3
   wb_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req_o && !wb_prev_q && have_q |-> wb_idx_o > last_q);

   // R4
   bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({spc_req_o, wb_req_o, inval_all_o, inval_one_o}));

   // R4
   inva_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inval_all_o |=> !inval_all_o);

   // R9
   done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inval_all_o || inval_one_o |=> done_o && !busy_o);

   // R9
   req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spc_req_o || wb_req_o || inval_all_o || inval_one_o |-> busy_o);
endmodule

bind flush_wb_seq flush_wb_seq_chk #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .line_mod_i (line_mod_i),
   .spc_req_o  (spc_req_o),
   .spc_done_i (spc_done_i),
   .wb_req_o   (wb_req_o),
   .wb_idx_o   (wb_idx_o),
   .wb_done_i  (wb_done_i),
   .inval_all_o(inval_all_o),
   .inval_one_o(inval_one_o),
   .busy_o     (busy_o),
   .done_o     (done_o)
);

// File: tb/flush_wb_seq_bench.sv
module flush_wb_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NL         = 16;
   localparam int IW         = $clog2(NL);
   localparam logic [2:0] K_SPC = 3'd0, K_WB = 3'd1, K_INVA = 3'd2,
                          K_INV1 = 3'd3, K_DONE = 3'd4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flush_n_i = 1'b1, wbinv_cmd_i = 1'b0, snoop_hit_i = 1'b0;
   logic [IW-1:0] snoop_idx_i = '0;
   logic [NL-1:0] line_mod = '0;
   logic          spc_done_i = 1'b0, wb_done_i = 1'b0;
   logic          spc_req_o, wb_req_o, inval_all_o, inval_one_o, busy_o, done_o;
   logic [IW-1:0] wb_idx_o, inval_idx_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   flush_wb_seq #(.NUM_LINES(NL)) u_flush_wb_seq (
      .clk(clk), .rst_n(rst_n), .flush_n_i(flush_n_i), .wbinv_cmd_i(wbinv_cmd_i),
      .snoop_hit_i(snoop_hit_i), .snoop_idx_i(snoop_idx_i), .line_mod_i(line_mod),
      .spc_req_o(spc_req_o), .spc_done_i(spc_done_i), .wb_req_o(wb_req_o),
      .wb_idx_o(wb_idx_o), .wb_done_i(wb_done_i), .inval_all_o(inval_all_o),
      .inval_one_o(inval_one_o), .inval_idx_o(inval_idx_o), .busy_o(busy_o),
      .done_o(done_o)
   );

   // expected-event queue: written by driver, consumed by monitor
   logic [2:0] exp_kind [0:255];
   int         exp_idx  [0:255];
   string      exp_tag  [0:255];
   int         wr_ptr = 0;
   int         rd_ptr = 0;
   int         drv_chk = 0, drv_err = 0, mon_chk = 0, mon_err = 0;
   int         done_seen = 0;
   int         lat = 1;
   bit         wd_fired = 1'b0;

   task automatic push(input logic [2:0] k, input int i, input string tag);
      exp_kind[wr_ptr % 256] = k;
      exp_idx[wr_ptr % 256]  = i;
      exp_tag[wr_ptr % 256]  = tag;
      wr_ptr++;
   endtask

   task automatic expect_scan(input bit with_ack, input string tag);
      if (with_ack) push(K_SPC, 0, tag);
      for (int i = 0; i < NL; i++) if (line_mod[i]) push(K_WB, i, tag);
      push(K_INVA, 0, tag);
      push(K_DONE, 0, tag);
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      drv_chk++;
      if (!ok) begin
         drv_err++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // bus-side responder
   int wcnt = 0, scnt = 0;
   always @(negedge clk) begin
      if (wb_req_o && !wb_done_i) begin
         if (wcnt >= lat) begin wb_done_i <= 1'b1; wcnt <= 0; end
         else wcnt <= wcnt + 1;
      end else wb_done_i <= 1'b0;
      if (spc_req_o && !spc_done_i) begin
         if (scnt >= lat) begin spc_done_i <= 1'b1; scnt <= 0; end
         else scnt <= scnt + 1;
      end else spc_done_i <= 1'b0;
   end

   // monitor
   logic prev_spc = 1'b0, prev_wb = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         logic [2:0] k;
         int         i;
         bit         ev;
         ev = 1'b1; i = 0; k = K_DONE;
         if (spc_req_o && !prev_spc)  k = K_SPC;
         else if (wb_req_o && !prev_wb) begin k = K_WB; i = int'(wb_idx_o); end
         else if (inval_all_o)         k = K_INVA;
         else if (inval_one_o) begin   k = K_INV1; i = int'(inval_idx_o); end
         else if (done_o)              k = K_DONE;
         else ev = 1'b0;
         if (ev) begin
            mon_chk++;
            if (rd_ptr >= wr_ptr) begin
               mon_err++;
               $display("FAIL R7/R8 unexpected event: actual kind=%0d idx=%0d expected=none", k, i);
            end else begin
               if (k != exp_kind[rd_ptr % 256] || i != exp_idx[rd_ptr % 256]) begin
                  mon_err++;
                  $display("FAIL %s: actual kind=%0d idx=%0d expected kind=%0d idx=%0d",
                           exp_tag[rd_ptr % 256], k, i, exp_kind[rd_ptr % 256], exp_idx[rd_ptr % 256]);
               end
               rd_ptr++;
            end
            if (k == K_DONE) begin
               done_seen++;
               mon_chk++;
               if (busy_o) begin
                  mon_err++;
                  $display("FAIL R9 busy at done: actual=1 expected=0");
               end
            end
         end
         prev_spc <= spc_req_o;
         prev_wb  <= wb_req_o;
      end
   end

   task automatic wait_done(input int base, input string tag);
      while (done_seen <= base) @(negedge clk);
      repeat (6) @(negedge clk);
      chk(rd_ptr == wr_ptr, tag, rd_ptr, wr_ptr);
      chk(!busy_o, tag, busy_o, 0);
   endtask

   task automatic pulse_cmd(input bit with_snoop, input int sidx);
      @(negedge clk);
      wbinv_cmd_i = 1'b1;
      if (with_snoop) begin snoop_hit_i = 1'b1; snoop_idx_i = IW'(sidx); end
      @(negedge clk);
      wbinv_cmd_i = 1'b0;
      snoop_hit_i = 1'b0;
   endtask

   task automatic pulse_snoop(input int sidx);
      @(negedge clk);
      snoop_hit_i = 1'b1; snoop_idx_i = IW'(sidx);
      @(negedge clk);
      snoop_hit_i = 1'b0;
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks",
               drv_err + mon_err + (wd_fired ? 1 : 0),
               drv_chk + mon_chk + (wd_fired ? 1 : 0));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      wd_fired = 1'b1;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      int base;
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk({spc_req_o, wb_req_o, inval_all_o, inval_one_o, busy_o, done_o} == 6'b0,
          "R11 outputs after reset",
          int'({spc_req_o, wb_req_o, inval_all_o, inval_one_o, busy_o, done_o}), 0);

      // R5 R2 R3: command with lines 0, 5 and last modified
      line_mod = '0; line_mod[0] = 1'b1; line_mod[5] = 1'b1; line_mod[NL-1] = 1'b1;
      lat = 2; base = done_seen;
      expect_scan(1'b0, "R5 cmd scan");
      pulse_cmd(1'b0, 0);
      chk(busy_o, "R9 busy after trigger", busy_o, 1);
      wait_done(base, "R5 cmd drained");

      // R1: flush with lines 3 and 7
      line_mod = '0; line_mod[3] = 1'b1; line_mod[7] = 1'b1;
      lat = 0; base = done_seen;
      expect_scan(1'b1, "R1 flush scan");
      @(negedge clk) flush_n_i = 1'b0;
      repeat (4) @(negedge clk);
      flush_n_i = 1'b1;
      wait_done(base, "R1 flush drained");

      // R3: flush with all lines clean
      line_mod = '0; base = done_seen;
      expect_scan(1'b1, "R3 clean flush");
      @(negedge clk) flush_n_i = 1'b0;
      repeat (3) @(negedge clk);
      flush_n_i = 1'b1;
      wait_done(base, "R3 clean flush drained");

      // R4: command with all lines clean
      base = done_seen;
      expect_scan(1'b0, "R4 clean cmd");
      pulse_cmd(1'b0, 0);
      wait_done(base, "R4 clean cmd drained");

      // R6: snoop on modified line 9
      line_mod = '0; line_mod[9] = 1'b1; lat = 1; base = done_seen;
      push(K_WB, 9, "R6 snoop dirty");
      push(K_INV1, 9, "R6 snoop dirty");
      push(K_DONE, 0, "R6 snoop dirty");
      pulse_snoop(9);
      wait_done(base, "R6 snoop dirty drained");

      // R6: snoop on clean line 4
      base = done_seen;
      push(K_INV1, 4, "R6 snoop clean");
      push(K_DONE, 0, "R6 snoop clean");
      pulse_snoop(4);
      wait_done(base, "R6 snoop clean drained");

      // R7 R8: all lines modified, flush edge and snoop arrive mid-scan
      line_mod = '1; lat = 1; base = done_seen;
      expect_scan(1'b0, "R8 busy flush");
      pulse_cmd(1'b0, 0);
      repeat (5) @(negedge clk);
      flush_n_i = 1'b0;
      repeat (3) @(negedge clk);
      flush_n_i = 1'b1;
      repeat (3) @(negedge clk);
      chk(busy_o, "R7 still busy before snoop", busy_o, 1);
      pulse_snoop(2);
      wait_done(base, "R7 R8 drained");

      // R8: flush held low after the operation does not retrigger
      line_mod = '0; line_mod[1] = 1'b1; base = done_seen;
      expect_scan(1'b1, "R8 held flush");
      @(negedge clk) flush_n_i = 1'b0;
      wait_done(base, "R8 held first op");
      repeat (20) @(negedge clk);
      chk(rd_ptr == wr_ptr && !busy_o, "R8 no retrigger", busy_o, 0);
      flush_n_i = 1'b1;
      repeat (5) @(negedge clk);

      // R10: command and snoop in the same idle cycle
      line_mod = '0; line_mod[2] = 1'b1; base = done_seen;
      expect_scan(1'b0, "R10 cmd over snoop");
      pulse_cmd(1'b1, 2);
      wait_done(base, "R10 drained");

      summary();
      $finish;
   end
endmodule